// File: doc/BRIEF.md
# Per-Lane Variable Vector Shifter

This block shifts every lane of a 128-bit operand vector by its own amount. The amount for each lane comes from the matching lane of a second 128-bit vector, read as a signed byte. A positive or zero amount shifts the lane toward its most significant end and fills with zeros. A negative amount shifts toward the least significant end. In signed mode that right shift copies the sign bit, and in unsigned mode it fills with zeros. When the magnitude of the amount reaches or exceeds the lane width, the whole lane reads zero.

A two-bit size code selects the lane width: 8, 16, 32 or 64 bits. A half-width select restricts the operation to the low 64 bits and forces the upper 64 bits of the result to zero. The result is registered, so it appears one clock after the operands are presented. A new operation may be started on every clock.

Top module: `vec_lane_shifter`

## Requirements
- R1: The count for a lane is bits [7:0] of the matching lane of `opb`, read as a two's-complement byte. All other bits of that lane have no effect on the result.
- R2: A count of zero or more shifts the lane left by that count, filling with zeros. Bits that move past the lane's top bit are lost.
- R3: A negative count with `arith` low shifts the lane right by the negated count, filling with zeros.
- R4: A negative count with `arith` high shifts the lane right by the negated count, filling with copies of the lane's top bit.
- R5: If the count magnitude is greater than or equal to the lane width, the lane result is zero. This includes -128, which is treated as magnitude 128.
- R6: `size_sel` 0, 1, 2 and 3 select lane widths of 8, 16, 32 and 64 bits. Lane i occupies bits [i*W +: W] of every vector.
- R7: When `half_mode` is high, `result[127:64]` is zero and the low 64 bits follow R1 to R6.
- R8: `result` is registered. It reflects the inputs sampled at the previous rising clock edge. A synchronous active-low reset clears it to zero.
- R9: A count of zero returns the lane unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| opa | input | 128 | Vector of values to shift |
| opb | input | 128 | Vector holding per-lane signed shift counts in each lane's low byte |
| size_sel | input | 2 | Lane width code: 0=8, 1=16, 2=32, 3=64 bits |
| arith | input | 1 | 1: right shifts copy the sign bit; 0: right shifts fill with zeros |
| half_mode | input | 1 | 1: operate on the low 64 bits only and zero the upper half |
| result | output | 128 | Registered shifted vector |

## Verification
Every result is due exactly one rising edge after its operands are sampled, and the reset clear appears at that same edge. The bench changes inputs on the falling edge. It compares `result` at the next falling edge against a behavioural model evaluated on the operands held in that window, so each comparison falls half a cycle after the register updates. Directed vectors cover each width at count zero, at the largest legal magnitude, at the width itself and at -128, with junk in the ignored count bits. A long stream of random operands is then compared on every clock.

// File: rtl/lsh_pkg.sv
// Package: shared widths and the lane size code for the per-lane shifter.
// Assumes a 128-bit datapath whose half-width mode keeps the low 64 bits.
package lsh_pkg;
    parameter int VEC_W  = 128;
    parameter int HALF_W = 64;
    parameter int CNT_W  = 8;
    parameter int N_SIZE = 4;

    typedef enum logic [1:0] {
        LSZ_B8  = 2'd0,
        LSZ_H16 = 2'd1,
        LSZ_W32 = 2'd2,
        LSZ_D64 = 2'd3
    } lane_size_e;
endpackage

// File: rtl/lsh_lane_unit.sv
// Module: one lane of the shifter. Decodes the signed count byte into a
// direction and a magnitude, then selects a left, logical-right or
// arithmetic-right shift, or zero when the magnitude reaches the width.
// Assumes LANE_W is a power of two between 8 and 64.
module lsh_lane_unit #(
    parameter int LANE_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic [LANE_W-1:0] lane_a,
    input  logic [LANE_W-1:0] lane_b,
    input  logic              arith,
    output logic [LANE_W-1:0] lane_y
);
    localparam int MAG_W = CNT_W + 1;
    localparam int SH_W  = $clog2(LANE_W);
    localparam logic [MAG_W-1:0] WIDTH_LIM = MAG_W'(LANE_W);

    logic [CNT_W-1:0] cnt_byte;
    logic             go_right;
    logic [MAG_W-1:0] mag;
    logic             too_far;
    logic [SH_W-1:0]  sh;
    logic [LANE_W-1:0] shl_v, shr_l, shr_a;

    assign cnt_byte = lane_b[CNT_W-1:0];

    // Count decode: direction from the sign bit, magnitude widened so -128 maps to 128
    always_comb begin
        go_right = cnt_byte[CNT_W-1];
        mag      = go_right ? (MAG_W'(0) - {1'b1, cnt_byte}) : {1'b0, cnt_byte};
        too_far  = (mag >= WIDTH_LIM);
        sh       = mag[SH_W-1:0];
    end

    // Shift candidates for the three directions/fills
    always_comb begin
        shl_v = lane_a << sh;
        shr_l = lane_a >> sh;
        shr_a = LANE_W'($signed(lane_a) >>> sh);
    end

    // Final lane selection
    always_comb begin
        if (too_far)       lane_y = '0;
        else if (!go_right) lane_y = shl_v;
        else if (arith)    lane_y = shr_a;
        else               lane_y = shr_l;
    end

    generate
        if (LANE_W > CNT_W) begin : g_hi_bits
            logic unused_cnt_hi;
            assign unused_cnt_hi = ^lane_b[LANE_W-1:CNT_W];
        end
    endgenerate

    // Lane-level checks on the selected result
    always_comb begin
        // R9
        if (cnt_byte == '0) begin
            lane_pass_chk: assert (lane_y == lane_a);
        end
        // R3
        if (go_right && !arith) begin
            lane_shrink_chk: assert (lane_y <= lane_a);
        end
        // R4
        if (go_right && arith && !too_far) begin
            lane_sign_chk: assert (lane_y[LANE_W-1] == lane_a[LANE_W-1]);
        end
    end
endmodule

// File: rtl/lsh_size_bank.sv
// Module: a full-width row of lane units for one lane width. Lane i uses
// bits [i*LANE_W +: LANE_W] of both operands.
// Assumes VEC_W is a multiple of LANE_W.
module lsh_size_bank #(
    parameter int VEC_W  = 128,
    parameter int LANE_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic [VEC_W-1:0] opa,
    input  logic [VEC_W-1:0] opb,
    input  logic             arith,
    output logic [VEC_W-1:0] bank_y
);
    localparam int N_LANE = VEC_W / LANE_W;

    genvar i;
    generate
        for (i = 0; i < N_LANE; i++) begin : g_lane
            lsh_lane_unit #(.LANE_W(LANE_W), .CNT_W(CNT_W)) u_lane (
                .lane_a (opa[i*LANE_W +: LANE_W]),
                .lane_b (opb[i*LANE_W +: LANE_W]),
                .arith  (arith),
                .lane_y (bank_y[i*LANE_W +: LANE_W])
            );
        end
    endgenerate
endmodule

// File: rtl/vec_lane_shifter.sv
// Module: top of the per-lane variable shifter. One bank per lane width runs
// in parallel; the size code picks a bank, half mode clears the upper half,
// and the result is registered (one cycle latency).
// Assumes synchronous active-low reset.
module vec_lane_shifter
    import lsh_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic [127:0] opa,
    input  logic [127:0] opb,
    input  logic [1:0]   size_sel,
    input  logic         arith,
    input  logic         half_mode,
    output logic [127:0] result
);
    logic [VEC_W-1:0] bank_y [N_SIZE];
    logic [VEC_W-1:0] next_y;
    lane_size_e       size_e;

    genvar s;
    generate
        for (s = 0; s < N_SIZE; s++) begin : g_size
            lsh_size_bank #(.VEC_W(VEC_W), .LANE_W(8 << s), .CNT_W(CNT_W)) u_bank (
                .opa    (opa),
                .opb    (opb),
                .arith  (arith),
                .bank_y (bank_y[s])
            );
        end
    endgenerate

    assign size_e = lane_size_e'(size_sel);

    // Bank selection by lane width and upper-half clearing
    always_comb begin
        next_y = bank_y[size_e];
        if (half_mode) next_y[VEC_W-1:HALF_W] = '0;
    end

    // Output register with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) result <= '0;
        else        result <= next_y;
    end

    // R7
    upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(half_mode) |-> (result[VEC_W-1:HALF_W] == '0));

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(opa) && $stable(opb) && $stable(size_sel)
         && $stable(arith) && $stable(half_mode)) |=> $stable(result));
endmodule

// File: tb/vec_lane_shifter_bench.sv
// Bench: drives operands on the falling edge, compares result one cycle
// later against a behavioural lane-by-lane model.
module vec_lane_shifter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYC = 100000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] opa = '0;
    logic [127:0] opb = '0;
    logic [1:0]   size_sel = '0;
    logic         arith = 1'b0;
    logic         half_mode = 1'b0;
    logic [127:0] result;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    vec_lane_shifter u_vec_lane_shifter (
        .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb),
        .size_sel(size_sel), .arith(arith), .half_mode(half_mode),
        .result(result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                           input int sz, input bit sgn, input bit hf);
        logic [127:0] r;
        logic [63:0]  la, mask, v, se;
        int w, nl, cnt, mag;
        r = '0;
        w = 8 << sz;
        nl = 128 / w;
        mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        for (int i = 0; i < nl; i++) begin
            if (hf && (i*w >= 64)) continue;
            la  = 64'(a >> (i*w)) & mask;
            cnt = int'($signed(b[i*w +: 8]));
            if (cnt >= 0) begin
                mag = cnt;
                v = (mag >= w) ? 64'd0 : ((la << mag) & mask);
            end else begin
                mag = -cnt;
                if (mag >= w) v = 64'd0;
                else if (sgn) begin
                    se = la[w-1] ? (la | ~mask) : la;
                    v  = 64'($signed(se) >>> mag) & mask;
                end else v = la >> mag;
            end
            r = r | (128'(v) << (i*w));
        end
        return r;
    endfunction

    task automatic check(input logic [127:0] exp, input string tag);
        n_vec++;
        if (result !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, result, exp);
        end
    endtask

    task automatic apply(input logic [127:0] a, input logic [127:0] b, input int sz,
                         input bit sgn, input bit hf, input string tag);
        logic [127:0] exp;
        opa = a; opb = b; size_sel = 2'(sz); arith = sgn; half_mode = hf;
        exp = model(a, b, sz, sgn, hf);
        @(posedge clk);
        @(negedge clk);
        check(exp, tag);
    endtask

    function automatic logic [127:0] fill_cnt(input int sz, input logic [7:0] c,
                                              input logic [7:0] junk);
        logic [127:0] r;
        int w;
        w = 8 << sz;
        r = '0;
        for (int i = 0; i < 16; i++) r[i*8 +: 8] = junk;
        for (int i = 0; i < 128 / w; i++) r[i*w +: 8] = c;
        return r;
    endfunction

    localparam logic [127:0] PAT = 128'h8123_4567_89AB_CDEF_F0E1_D2C3_B4A5_9687;

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check(128'd0, "R8 reset");
        rst_n = 1'b1;

        for (int sz = 0; sz < 4; sz++) begin
            int w;
            w = 8 << sz;
            // R9: zero count passes through, junk above low byte (R1)
            apply(PAT, fill_cnt(sz, 8'd0, 8'hA5), sz, 1'b0, 1'b0, "R9 zero count");
            // R2: left shift by 3 and by width-1
            apply(PAT, fill_cnt(sz, 8'd3, 8'h7F), sz, 1'b0, 1'b0, "R2 left 3");
            apply(PAT, fill_cnt(sz, 8'(w-1), 8'h00), sz, 1'b1, 1'b0, "R2 left max");
            // R3: logical right
            apply(PAT, fill_cnt(sz, 8'hFD, 8'hFF), sz, 1'b0, 1'b0, "R3 right logical");
            apply(PAT, fill_cnt(sz, 8'(-(w-1)), 8'h11), sz, 1'b0, 1'b0, "R3 right max");
            // R4: arithmetic right
            apply(PAT, fill_cnt(sz, 8'hFD, 8'hFF), sz, 1'b1, 1'b0, "R4 right arith");
            apply(PAT, fill_cnt(sz, 8'(-(w-1)), 8'h22), sz, 1'b1, 1'b0, "R4 right arith max");
            // R5: magnitude at width and -128
            apply(PAT, fill_cnt(sz, 8'(w), 8'h00), sz, 1'b0, 1'b0, "R5 left width");
            apply(PAT, fill_cnt(sz, 8'(-w), 8'h00), sz, 1'b1, 1'b0, "R5 right width");
            apply(PAT, fill_cnt(sz, 8'h80, 8'h00), sz, 1'b1, 1'b0, "R5 minus 128");
            // R7: half mode
            apply(PAT, fill_cnt(sz, 8'd1, 8'h5A), sz, 1'b1, 1'b1, "R7 half mode");
        end

        // R1: upper byte of a 16-bit count lane is junk; only low byte counts
        apply(PAT, {8{16'hFF02}}, 1, 1'b0, 1'b0, "R1 high bits ignored");
        // R6: mixed per-lane counts at every width
        for (int sz = 0; sz < 4; sz++)
            apply(PAT, 128'h0102_0304_F0F8_FC7F_0500_FF01_80FE_0807, sz, 1'b1, 1'b0, "R6 mixed lanes");

        // R8: mid-run reset clears result
        opa = PAT; opb = '0;
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check(128'd0, "R8 mid reset");
        rst_n = 1'b1;

        // Random stream compared every clock
        for (int k = 0; k < 2000; k++) begin
            logic [127:0] ra, rb;
            ra = {$urandom, $urandom, $urandom, $urandom};
            rb = {$urandom, $urandom, $urandom, $urandom};
            apply(ra, rb, int'($urandom % 4), 1'($urandom), 1'($urandom), "R6 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule